// File: doc/BRIEF.md
# SPI Configuration Port Target

This block is the device side of a byte-wide programming port reached over SPI (mode 0, most significant bit first). A host opens a window by pulling chip select low and clocks in an opcode followed by any operand or payload bytes. The target returns its status byte on MISO during the first byte of every window, whatever opcode is being sent. All bytes after the first read back as zero, which is also the all-zero result the host expects when it reads the outcome of the enable command.

The target keeps two mode flags: a configuration-enable flag and a program-mode flag. In program mode it accepts 16-byte configuration frames and presents each completed frame on a wide output with a one-cycle strobe. Every accepted state-changing command or frame starts a busy period of a parameterised number of clocks. Protocol misuse sets sticky violation and error bits that only reset clears. Examples of misuse are an unknown opcode, a command sent while busy, or a frame sent outside program mode.

The SPI pins are sampled in the system clock domain through synchronisers, so the serial clock must run well below the system clock.

Top module: `cfgport_target`

## Requirements
- R1: After reset, all mode flags, busy, ready, violation and error are 0, frameValid is 0, and the status byte reads 0x00.
- R2: The first byte shifted out on MISO in every window is the status byte as it stood when chip select fell: bit0 busy, bit1 ready, bit2 violation, bit3 error, bits 7..4 zero. Every byte after it reads 0x00.
- R3: A window holding only opcode 0x0B sets cfgEnable and ready. A window holding only 0x0C clears both.
- R4: Opcode 0x01 clears ready when its byte completes. The bytes that follow it read 0x00 (an all-zero result).
- R5: The window 0xAE, 0x01 sets progMode only while cfgEnable is 1. A window holding only 0x23 clears progMode.
- R6: In program mode, a window of 0xEE followed by 16 bytes gives one single-cycle frameValid pulse. frameData then holds the payload with its first byte in bits 127..120.
- R7: Busy rises when a frame completes, or when an 0x0B, 0x0C, accepted 0xAE or 0x23 window closes. It stays set for BUSY_CYCLES clocks and then clears.
- R8: Any opcode other than 0x00 whose byte completes while busy is ignored and sets violation.
- R9: These also set violation and change nothing else: an unknown opcode, 0xEE outside program mode, 0xAE without cfgEnable or with a mode byte other than 0x01, wrong-length single-byte commands, and payload bytes beyond the 16th.
- R10: Chip select rising before 16 payload bytes have arrived, or in the middle of a byte, sets error. A frame cut short produces no frameValid.
- R11: Violation and error stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSclk | input | 1 | SPI serial clock (idle low) |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host, 0 while deselected |
| frameData | output | FRAME_BYTES*8 | Last completed frame payload, first byte at top |
| frameValid | output | 1 | One-cycle strobe for a new frame |
| progMode | output | 1 | Program-mode flag |
| cfgEnable | output | 1 | Configuration-enable flag |
| busy | output | 1 | Busy period active |
| statusReg | output | 8 | Live status byte |

## Verification
Every pin change passes two synchroniser stages and one edge-detect register. A flag set at chip-select rise, the load of MISO at chip-select fall, and a frame strobe after the last serial-clock rise therefore all land on the third system clock edge after the pin moves. The bench waits six clocks after each window before it compares flags. It reads MISO four clocks after each falling serial-clock edge, and it catches frame strobes with a monitor that runs on every falling system clock edge. Busy is tested inside a window that both ends are sure of: it must still be set BUSY_CYCLES−4 clocks after the closing pin edge, and it must be clear by BUSY_CYCLES+16.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] OP_CFG_ON    = 8'h0B;
  localparam logic [7:0] OP_CFG_OFF   = 8'h0C;
  localparam logic [7:0] OP_STATUS    = 8'h00;
  localparam logic [7:0] OP_FETCH     = 8'h01;
  localparam logic [7:0] OP_MODE      = 8'hAE;
  localparam logic [7:0] OP_FRAME     = 8'hEE;
  localparam logic [7:0] OP_RELEASE   = 8'h23;
  localparam logic [7:0] MODE_PROGRAM = 8'h01;

  localparam int ST_BUSY  = 0;
  localparam int ST_READY = 1;
  localparam int ST_VIOL  = 2;
  localparam int ST_ERR   = 3;

  localparam int IDX_W = 6;  // byte index saturates at 63

  typedef struct packed {
    logic             csFall;
    logic             csRise;
    logic             byteDone;
    logic             midByte;
    logic [7:0]       byteVal;
    logic [IDX_W-1:0] byteIdx;
  } spiEvt_t;

  typedef struct packed {
    logic frameCollect;
    logic frameCommit;
  } ctrlStb_t;
endpackage

// File: rtl/cfgport_dp.sv
module cfgport_dp
  import cfgport_pkg::*;
#(
  parameter int FRAME_BYTES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclkPin,
  input  logic                     csNPin,
  input  logic                     mosiPin,
  output logic                     misoPin,
  input  logic [7:0]               statusByte,
  input  ctrlStb_t                 stb,
  output spiEvt_t                  evt,
  output logic [FRAME_BYTES*8-1:0] frameData,
  output logic                     frameValid
);
  localparam int PAY_W   = (FRAME_BYTES - 1) * 8;
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkS, csS, mosiS, sclkPrev, csPrev;
  logic sclkRise, sclkFall, csActive;
  logic [2:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic [IDX_W-1:0] byteCnt;
  logic [PAY_W-1:0] frameBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkPin};
      csSync   <= {csSync[SYNC_STAGES-2:0], csNPin};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiPin};
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign csS      = csSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign csActive = ~csS;
  assign sclkRise = csActive & sclkS & ~sclkPrev;
  assign sclkFall = csActive & ~sclkS & sclkPrev;

  always_comb begin
    evt.csFall   = ~csS & csPrev;
    evt.csRise   = csS & ~csPrev;
    evt.byteDone = sclkRise && (bitCnt == 3'd7);
    evt.midByte  = (bitCnt != 3'd0);
    evt.byteVal  = {rxShift[6:0], mosiS};
    evt.byteIdx  = byteCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      byteCnt <= '0;
    end else if (evt.csFall) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      txShift <= statusByte;
    end else begin
      if (sclkRise) begin
        rxShift <= evt.byteVal;
        bitCnt  <= bitCnt + 3'd1;
        if (evt.byteDone && byteCnt != IDX_W'(IDX_MAX))
          byteCnt <= byteCnt + 1'b1;
      end
      if (sclkFall)
        txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign misoPin = csActive & txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBuf   <= '0;
      frameData  <= '0;
      frameValid <= 1'b0;
    end else begin
      frameValid <= stb.frameCommit;
      if (stb.frameCollect)
        frameBuf <= {frameBuf[PAY_W-9:0], evt.byteVal};
      if (stb.frameCommit)
        frameData <= {frameBuf, evt.byteVal};
    end
  end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int FRAME_BYTES = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiEvt_t    evt,
  output ctrlStb_t   stb,
  output logic [7:0] statusByte,
  output logic       progMode,
  output logic       cfgEnable
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]       opcode, modeByte;
  logic             cmdOk, frameSent, ready, viol, err;
  logic [CNT_W-1:0] busyCnt;
  logic             busyNow, opcodeByte, acceptOp, payloadByte;
  logic             endAccept, endBusy, startBusy;

  function automatic logic knownOp(input logic [7:0] op);
    return op inside {OP_CFG_ON, OP_CFG_OFF, OP_STATUS, OP_FETCH,
                      OP_MODE, OP_FRAME, OP_RELEASE};
  endfunction

  assign busyNow    = (busyCnt != '0);
  assign opcodeByte = evt.byteDone && (evt.byteIdx == '0);
  assign acceptOp   = knownOp(evt.byteVal)
                   && (!busyNow || evt.byteVal == OP_STATUS)
                   && !(evt.byteVal == OP_FRAME && !progMode);
  assign payloadByte = evt.byteDone && (evt.byteIdx != '0) && cmdOk
                    && (opcode == OP_FRAME);

  assign stb.frameCollect = payloadByte && (evt.byteIdx < IDX_W'(FRAME_BYTES));
  assign stb.frameCommit  = payloadByte && (evt.byteIdx == IDX_W'(FRAME_BYTES));

  always_comb begin
    endAccept = 1'b1;
    endBusy   = 1'b0;
    unique case (opcode)
      OP_CFG_ON, OP_CFG_OFF, OP_RELEASE: begin
        endAccept = (evt.byteIdx == IDX_W'(1));
        endBusy   = endAccept;
      end
      OP_MODE: begin
        endAccept = (evt.byteIdx == IDX_W'(2)) && (modeByte == MODE_PROGRAM) && cfgEnable;
        endBusy   = endAccept;
      end
      default: ;
    endcase
  end

  assign startBusy = stb.frameCommit || (evt.csRise && cmdOk && endBusy);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode    <= '0;
      modeByte  <= '0;
      cmdOk     <= 1'b0;
      frameSent <= 1'b0;
      ready     <= 1'b0;
      viol      <= 1'b0;
      err       <= 1'b0;
      progMode  <= 1'b0;
      cfgEnable <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (startBusy)
        busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busyNow)
        busyCnt <= busyCnt - 1'b1;

      if (opcodeByte) begin
        opcode <= evt.byteVal;
        cmdOk  <= acceptOp;
        if (!acceptOp) viol <= 1'b1;
        if (acceptOp && evt.byteVal == OP_FETCH) ready <= 1'b0;
      end

      if (evt.byteDone && evt.byteIdx == IDX_W'(1))
        modeByte <= evt.byteVal;
      if (payloadByte && evt.byteIdx > IDX_W'(FRAME_BYTES))
        viol <= 1'b1;
      if (stb.frameCommit)
        frameSent <= 1'b1;

      if (evt.csRise) begin
        if (evt.midByte) err <= 1'b1;
        if (cmdOk) begin
          if (!endAccept) viol <= 1'b1;
          if (endAccept) begin
            unique case (opcode)
              OP_CFG_ON:  begin cfgEnable <= 1'b1; ready <= 1'b1; end
              OP_CFG_OFF: begin cfgEnable <= 1'b0; ready <= 1'b0; end
              OP_MODE:    progMode <= 1'b1;
              OP_RELEASE: progMode <= 1'b0;
              default: ;
            endcase
          end
          if (opcode == OP_FRAME && !frameSent) err <= 1'b1;
        end
        cmdOk     <= 1'b0;
        frameSent <= 1'b0;
      end
    end
  end

  always_comb begin
    statusByte           = '0;
    statusByte[ST_BUSY]  = busyNow;
    statusByte[ST_READY] = ready;
    statusByte[ST_VIOL]  = viol;
    statusByte[ST_ERR]   = err;
  end
endmodule

// File: rtl/cfgport_target.sv
module cfgport_target
  import cfgport_pkg::*;
#(
  parameter int FRAME_BYTES = 16,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     spiSclk,
  input  logic                     spiCsN,
  input  logic                     spiMosi,
  output logic                     spiMiso,
  output logic [FRAME_BYTES*8-1:0] frameData,
  output logic                     frameValid,
  output logic                     progMode,
  output logic                     cfgEnable,
  output logic                     busy,
  output logic [7:0]               statusReg
);
  spiEvt_t    evt;
  ctrlStb_t   stb;
  logic [7:0] statusByte;

  cfgport_dp #(.FRAME_BYTES(FRAME_BYTES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclkPin(spiSclk), .csNPin(spiCsN),
    .mosiPin(spiMosi), .misoPin(spiMiso), .statusByte(statusByte),
    .stb(stb), .evt(evt), .frameData(frameData), .frameValid(frameValid)
  );

  cfgport_ctrl #(.FRAME_BYTES(FRAME_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .stb(stb), .statusByte(statusByte),
    .progMode(progMode), .cfgEnable(cfgEnable)
  );

  assign statusReg = statusByte;
  assign busy      = statusByte[ST_BUSY];
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameValid,
  input logic       progMode,
  input logic       cfgEnable,
  input logic       busy,
  input logic [7:0] statusReg
);
  AST_FRAME_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> progMode); // R6
  AST_FRAME_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid); // R6
  AST_FRAME_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> busy); // R7
  AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[1] |-> cfgEnable); // R3
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[2] |=> statusReg[2]); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[3] |=> statusReg[3]); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[7:4] == 4'b0); // R2
endmodule

bind cfgport_target cfgport_checker u_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .progMode(progMode),
  .cfgEnable(cfgEnable), .busy(busy), .statusReg(statusReg)
);

// File: tb/test_cfgport_target.sv
module test_cfgport_target;
  localparam int CLK_PERIOD = 10;
  localparam int FB   = 16;
  localparam int BUSY = 120;
  localparam int HALF = 4;

  logic clk = 0, rstN = 0, sclk = 0, csN = 1, mosi = 0;
  logic miso, frameValid, progMode, cfgEnable, busy;
  logic [FB*8-1:0] frameData;
  logic [7:0] statusReg;

  cfgport_target #(.FRAME_BYTES(FB), .BUSY_CYCLES(BUSY)) i_cfgport_target (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiCsN(csN), .spiMosi(mosi),
    .spiMiso(miso), .frameData(frameData), .frameValid(frameValid),
    .progMode(progMode), .cfgEnable(cfgEnable), .busy(busy), .statusReg(statusReg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, frameCount = 0;
  bit done = 0;
  logic [FB*8-1:0] lastFrame;
  logic [7:0] txB[0:31];
  logic [7:0] rxB[0:31];
  bit mEn, mRdy, mProg, mViol, mErr, mFrame;
  logic [FB*8-1:0] mPayload;

  always @(negedge clk) if (frameValid) begin frameCount++; lastFrame = frameData; end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus(input bit b);
    return {4'b0, mErr, mViol, mRdy, b};
  endfunction

  task automatic doReset();
    rstN = 0; csN = 1; sclk = 0; mosi = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    {mEn, mRdy, mProg, mViol, mErr} = '0;
  endtask

  task automatic window(input int n, input int extraBits);
    csN = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i <= n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (i == n && (7 - b) >= extraBits) break;
        mosi = txB[i][b];
        repeat (HALF) @(negedge clk);
        rxB[i][b] = miso;
        sclk = 1;
        repeat (HALF) @(negedge clk);
        sclk = 0;
      end
    end
    repeat (HALF) @(negedge clk);
    csN = 1;
    repeat (6) @(negedge clk);
  endtask

  // expected effect of one window, computed from the requirements
  task automatic model(input int n, input int extraBits, input bit busyNow);
    mFrame = 0;
    if (extraBits != 0) mErr = 1;                              // R10
    if (n == 0) return;
    if (!(txB[0] inside {8'h0B, 8'h0C, 8'h00, 8'h01, 8'hAE, 8'hEE, 8'h23})
        || (busyNow && txB[0] != 8'h00) || (txB[0] == 8'hEE && !mProg)) begin
      mViol = 1; return;                                       // R8 R9
    end
    case (txB[0])
      8'h0B: if (n == 1) begin mEn = 1; mRdy = 1; end else mViol = 1;
      8'h0C: if (n == 1) begin mEn = 0; mRdy = 0; end else mViol = 1;
      8'h23: if (n == 1) mProg = 0; else mViol = 1;
      8'hAE: if (n == 2 && txB[1] == 8'h01 && mEn) mProg = 1; else mViol = 1;
      8'h01: mRdy = 0;
      8'hEE: begin
        if (n >= FB + 1) begin
          mFrame = 1;
          mPayload = '0;
          for (int i = 1; i <= FB; i++) mPayload = {mPayload[FB*8-9:0], txB[i]};
        end else mErr = 1;
        if (n > FB + 1) mViol = 1;
      end
      default: ;
    endcase
  endtask

  task automatic cmd(input int n, input int extraBits, input bit busyNow, input bit settle, input string req);
    logic [7:0] snap;
    int fc0;
    snap = expStatus(busyNow);
    fc0 = frameCount;
    window(n, extraBits);
    model(n, extraBits, busyNow);
    if (n > 0) check({"R2 status byte ", req}, rxB[0], snap);
    for (int i = 1; i < n; i++) check({"R2/R4 trailing byte ", req}, rxB[i], 8'h00);
    check({"R3 cfgEnable ", req}, cfgEnable, mEn);
    check({"R5 progMode ", req}, progMode, mProg);
    check({"R11 status flags ", req}, statusReg[3:1], {mErr, mViol, mRdy});
    check({"R6/R10 frame count ", req}, frameCount - fc0, mFrame);
    if (mFrame) check({"R6 payload ", req}, lastFrame, mPayload);
    if (settle) repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic setOp(input logic [7:0] a, input logic [7:0] b);
    txB[0] = a; txB[1] = b;
  endtask

  task automatic fillPayload();
    for (int i = 1; i < 32; i++) txB[i] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    doReset();
    // R1 reset state
    check("R1 status after reset", statusReg, 8'h00);
    check("R1 flags after reset", {progMode, cfgEnable, busy, frameValid, miso}, 5'b0);

    setOp(8'h00, 0); cmd(1, 0, 0, 1, "R2 read status");
    setOp(8'h0B, 0); cmd(1, 0, 0, 0, "R3 enable");
    check("R7 busy after enable", busy, 1'b1);
    repeat (BUSY - 10) @(negedge clk);
    check("R7 busy still held", busy, 1'b1);
    repeat (20) @(negedge clk);
    check("R7 busy cleared", busy, 1'b0);
    setOp(8'h00, 0); cmd(2, 0, 0, 1, "R2 ready visible");
    setOp(8'h01, 0); for (int i = 1; i < 5; i++) txB[i] = 8'hFF;
    cmd(5, 0, 0, 1, "R4 fetch result");
    setOp(8'hAE, 8'h01); cmd(2, 0, 0, 1, "R5 enter program");
    fillPayload(); txB[0] = 8'hEE; cmd(FB + 1, 0, 0, 1, "R6 frame");
    fillPayload(); txB[0] = 8'hEE; cmd(FB + 1, 0, 0, 1, "R6 frame 2");
    setOp(8'h23, 0); cmd(1, 0, 0, 1, "R5 release");

    // R8 command while busy
    doReset();
    setOp(8'h0B, 0); cmd(1, 0, 0, 0, "R8 enable");
    setOp(8'h0C, 0); cmd(1, 0, 1, 1, "R8 disable while busy");
    check("R8 command ignored", cfgEnable, 1'b1);

    // R9 frame outside program mode, then R11 stickiness
    doReset();
    fillPayload(); txB[0] = 8'hEE; cmd(FB + 1, 0, 0, 1, "R9 frame outside program");
    setOp(8'h00, 0); cmd(1, 0, 0, 1, "R11 violation held");
    setOp(8'hAE, 8'h01); cmd(2, 0, 0, 1, "R9 mode without enable");

    // R10 truncated frame
    doReset();
    setOp(8'h0B, 0); cmd(1, 0, 0, 1, "R10 setup enable");
    setOp(8'hAE, 8'h01); cmd(2, 0, 0, 1, "R10 setup program");
    fillPayload(); txB[0] = 8'hEE; cmd(9, 0, 0, 1, "R10 short frame");
    doReset();
    setOp(8'h00, 0); cmd(1, 3, 0, 1, "R10 partial byte");

    // random phase
    doReset();
    for (int k = 0; k < 40; k++) begin
      int sel, n, extra;
      fillPayload();
      sel = $urandom_range(0, 9);
      n = 1; extra = 0;
      case (sel)
        0: txB[0] = 8'h0B;
        1: txB[0] = 8'h0C;
        2: begin txB[0] = 8'hAE; txB[1] = 8'h01; n = 2; end
        3: begin txB[0] = 8'hAE; n = 2; end
        4: txB[0] = 8'h23;
        5, 6: begin txB[0] = 8'hEE; n = FB + 1; end
        7: begin txB[0] = 8'h01; n = $urandom_range(1, 5); end
        8: begin txB[0] = 8'hEE; n = $urandom_range(1, FB + 2); end
        default: begin txB[0] = 8'h55; extra = ($urandom_range(0, 3) == 0) ? 5 : 0; end
      endcase
      cmd(n, extra, 0, 1, "R9 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule